// File: doc/BRIEF.md
# Programmable Interval Timer Channel

A single 16-bit timer channel that counts input ticks after a mode and a count have been written. The ticks arrive on a one-clock clock-enable strobe. It has a gate input and one output line, and it offers six counting behaviours: a terminal-count flag, a gate-triggered one-shot, a periodic rate pulse, a square wave, and two single-tick strobes. One strobe starts from the count write and the other from a gate edge. A neighbouring register-interface block writes the mode and the count. That block also reads the visible count and the output level for its latch and status logic.

The channel stores the BCD flag that comes with a mode write but always counts in binary. A loaded count of zero stands for 65536. Mode field values 6 and 7 are folded to 2 and 3. The visible count and the output line are registered. They reflect each state change at the same clock edge that makes it.

Top module: `pit_channel`

## Requirements
- R1: After reset, out_o is 0, count_o is 0, mode_o is 0 and bcd_o is 0. A count write made before any mode write has no effect on out_o or count_o.
- R2: A written count of 0 behaves as 65536. In mode 0, out_o stays low for 65535 counting ticks and rises on the 65536th.
- R3: Mode 0 (terminal flag): from the count write, out_o is low until the loaded count of ticks has elapsed, then high until the next write. count_o drops by one per tick and wraps past zero.
- R4: Mode 1 (gate one-shot): out_o is high after the mode write and after the count write. A gate rising edge drives it low, and it goes high again once the loaded count of ticks has elapsed.
- R5: Mode 2 (rate): out_o is high for one tick at the end of every period of the loaded count of ticks, never on the load itself. count_o runs from the count down to 1, then reloads.
- R6: Mode 3 (square): within each period of N ticks, out_o is high for the first (N+1)/2 ticks and low for the rest. count_o falls by two per tick, modulo N, starting at N.
- R7: Modes 4 (write strobe) and 5 (gate strobe): out_o is high for exactly one tick, when the elapsed ticks equal the loaded count. Mode 4 starts at the count write and mode 5 at a gate rising edge.
- R8: In modes 1, 2, 3 and 5, a gate rising edge restarts the count from the loaded value.
- R9: In modes 0, 2, 3 and 4, ticks are counted only while gate is high. In modes 0 and 4 a gate edge does not restart the count.
- R10: Mode field values 6 and 7 behave as modes 2 and 3, and mode_o reads back the folded value.
- R11: A count write restarts the period from that write, in place of any count in progress.
- R12: State advances only on clocks where tick is high. Without tick, a write or a gate edge, count_o and out_o hold.
- R13: A mode write stops counting, sets count_o to 0 and stores bcd_i in bcd_o. out_o goes high for modes 1 and 3 and low for the others until counting starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-clock counting strobe |
| gate | input | 1 | Gate level; rising edge triggers in modes 1, 2, 3, 5 |
| wr_mode | input | 1 | Mode write strobe |
| mode_i | input | 3 | Mode field for a mode write |
| bcd_i | input | 1 | BCD flag stored with the mode |
| wr_cnt | input | 1 | Count write strobe |
| count_i | input | CW | Count value for a count write (0 means 2^CW) |
| out_o | output | 1 | Registered output level |
| count_o | output | CW | Registered visible count |
| mode_o | output | 3 | Folded mode currently in force |
| bcd_o | output | 1 | Stored BCD flag |

## Verification
Each mode is walked tick by tick with a small count. Odd and even periods separate the two halves of the square wave, and a continuing walk shows that the strobe modes do not repeat. Gate patterns are split into a level held low, which must freeze the count in the enable modes, and a low-to-high edge, which must restart it in the trigger modes. A sparse tick pattern separates tick gating from clock counting, and a full 65536-tick run with a zero count exposes any off-by-one at the zero boundary. Writes in the middle of a period check that a new count restarts the period.

// File: rtl/pit_pkg.sv
package pit_pkg;

  typedef enum logic [2:0] {
    M_TC_FLAG   = 3'd0,
    M_ONESHOT   = 3'd1,
    M_RATE      = 3'd2,
    M_SQUARE    = 3'd3,
    M_SW_STROBE = 3'd4,
    M_HW_STROBE = 3'd5
  } pit_mode_e;

  // Field values 6 and 7 fold onto 2 and 3 by dropping the top bit.
  function automatic pit_mode_e fold_mode(input logic [2:0] raw);
    logic [2:0] m;
    m = (raw[2] && raw[1]) ? {1'b0, raw[1:0]} : raw;
    return pit_mode_e'(m);
  endfunction

  function automatic logic is_periodic(input pit_mode_e m);
    return (m == M_RATE) || (m == M_SQUARE);
  endfunction

  // Modes whose counting begins only at a gate rising edge.
  function automatic logic waits_trigger(input pit_mode_e m);
    return (m == M_ONESHOT) || (m == M_HW_STROBE);
  endfunction

  function automatic logic gate_restarts(input pit_mode_e m);
    return waits_trigger(m) || is_periodic(m);
  endfunction

  function automatic logic idle_high(input pit_mode_e m);
    return (m == M_ONESHOT) || (m == M_SQUARE);
  endfunction

endpackage

// File: rtl/pit_ctrl.sv
module pit_ctrl
  import pit_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_mode,
  input  logic [2:0] mode_in,
  input  logic       bcd_in,
  input  logic       gate,
  output pit_mode_e  mode_q,
  output pit_mode_e  mode_nxt,
  output logic       bcd_q,
  output logic       cfg_ok,
  output logic       trig
);

  logic gate_q;

  always_comb mode_nxt = wr_mode ? fold_mode(mode_in) : mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= M_TC_FLAG;
      bcd_q  <= 1'b0;
      cfg_ok <= 1'b0;
    end else if (wr_mode) begin
      mode_q <= mode_nxt;
      bcd_q  <= bcd_in;
      cfg_ok <= 1'b1;
    end
  end

  // Gate history follows the pin on every clock, reset or not.
  always_ff @(posedge clk) gate_q <= gate;

  assign trig = gate & ~gate_q;

endmodule

// File: rtl/pit_count.sv
module pit_count
  import pit_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  pit_mode_e     mode,
  input  logic          cfg_ok,
  input  logic          wr_mode,
  input  logic          wr_cnt,
  input  logic [CW-1:0] cnt_in,
  input  logic          tick,
  input  logic          gate,
  input  logic          trig,
  output logic          started_n,
  output logic          wrapped_n,
  output logic [CW:0]   reload_n,
  output logic [CW:0]   elapsed_n,
  output logic [CW-1:0] down_n
);

  localparam int RW = CW + 1;
  localparam logic [RW-1:0] FULL  = {1'b1, {CW{1'b0}}};
  localparam logic [RW-1:0] ONE_R = RW'(1);
  localparam logic [CW-1:0] ONE_C = CW'(1);

  logic          started_r, loaded_r, wrapped_r, loaded_n;
  logic [RW-1:0] reload_r, elapsed_r, inc;
  logic [CW-1:0] down_r;
  logic          run;

  assign inc = elapsed_r + ONE_R;
  assign run = tick && started_r && (waits_trigger(mode) || gate);

  always_comb begin
    started_n = started_r;
    loaded_n  = loaded_r;
    wrapped_n = wrapped_r;
    reload_n  = reload_r;
    elapsed_n = elapsed_r;
    down_n    = down_r;
    if (wr_mode) begin
      started_n = 1'b0;
      loaded_n  = 1'b0;
      wrapped_n = 1'b0;
      elapsed_n = '0;
      down_n    = '0;
    end else if (wr_cnt && cfg_ok) begin
      reload_n  = (cnt_in == '0) ? FULL : {1'b0, cnt_in};
      down_n    = cnt_in;
      elapsed_n = '0;
      wrapped_n = 1'b0;
      loaded_n  = 1'b1;
      started_n = !waits_trigger(mode);
    end else if (trig && loaded_r && gate_restarts(mode)) begin
      started_n = 1'b1;
      elapsed_n = '0;
      wrapped_n = 1'b0;
      down_n    = reload_r[CW-1:0];
    end else if (run) begin
      down_n = down_r - ONE_C;
      if (is_periodic(mode)) begin
        if (inc == reload_r) begin
          elapsed_n = '0;
          wrapped_n = 1'b1;
        end else begin
          elapsed_n = inc;
        end
      end else if (elapsed_r <= reload_r) begin
        // One-shot modes stop one step past the count.
        elapsed_n = inc;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      started_r <= 1'b0;
      loaded_r  <= 1'b0;
      wrapped_r <= 1'b0;
      reload_r  <= '0;
      elapsed_r <= '0;
      down_r    <= '0;
    end else begin
      started_r <= started_n;
      loaded_r  <= loaded_n;
      wrapped_r <= wrapped_n;
      reload_r  <= reload_n;
      elapsed_r <= elapsed_n;
      down_r    <= down_n;
    end
  end

endmodule

// File: rtl/pit_view.sv
module pit_view
  import pit_pkg::*;
#(
  parameter int CW = 16
) (
  input  pit_mode_e     mode,
  input  logic          started,
  input  logic          wrapped,
  input  logic [CW:0]   reload,
  input  logic [CW:0]   elapsed,
  input  logic [CW-1:0] down,
  output logic          lvl,
  output logic [CW-1:0] shown
);

  localparam int XW = CW + 2;

  logic [XW-1:0] twice, rel_x, half, fold;

  assign twice = {elapsed, 1'b0};
  assign rel_x = {1'b0, reload};
  assign half  = (rel_x + XW'(1)) >> 1;
  assign fold  = (twice >= rel_x) ? (twice - rel_x) : twice;

  always_comb begin
    lvl   = 1'b0;
    shown = down;
    if (!started) begin
      lvl = idle_high(mode);
    end else begin
      case (mode)
        M_TC_FLAG, M_ONESHOT: lvl = (elapsed >= reload);
        M_RATE: begin
          lvl   = wrapped && (elapsed == '0);
          shown = CW'(reload - elapsed);
        end
        M_SQUARE: begin
          lvl   = ({1'b0, elapsed} < half);
          shown = CW'(rel_x - fold);
        end
        default: lvl = (elapsed == reload);
      endcase
    end
  end

endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          gate,
  input  logic          wr_mode,
  input  logic [2:0]    mode_i,
  input  logic          bcd_i,
  input  logic          wr_cnt,
  input  logic [CW-1:0] count_i,
  output logic          out_o,
  output logic [CW-1:0] count_o,
  output logic [2:0]    mode_o,
  output logic          bcd_o
);

  pit_mode_e     mode_q, mode_nxt;
  logic          cfg_ok, trig;
  logic          started_n, wrapped_n, lvl;
  logic [CW:0]   reload_n, elapsed_n;
  logic [CW-1:0] down_n, shown;

  pit_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .wr_mode  (wr_mode),
    .mode_in  (mode_i),
    .bcd_in   (bcd_i),
    .gate     (gate),
    .mode_q   (mode_q),
    .mode_nxt (mode_nxt),
    .bcd_q    (bcd_o),
    .cfg_ok   (cfg_ok),
    .trig     (trig)
  );

  pit_count #(.CW(CW)) u_count (
    .clk       (clk),
    .rst       (rst),
    .mode      (mode_q),
    .cfg_ok    (cfg_ok),
    .wr_mode   (wr_mode),
    .wr_cnt    (wr_cnt),
    .cnt_in    (count_i),
    .tick      (tick),
    .gate      (gate),
    .trig      (trig),
    .started_n (started_n),
    .wrapped_n (wrapped_n),
    .reload_n  (reload_n),
    .elapsed_n (elapsed_n),
    .down_n    (down_n)
  );

  // Decode from next state so the outputs move on the same edge as the state.
  pit_view #(.CW(CW)) u_view (
    .mode    (mode_nxt),
    .started (started_n),
    .wrapped (wrapped_n),
    .reload  (reload_n),
    .elapsed (elapsed_n),
    .down    (down_n),
    .lvl     (lvl),
    .shown   (shown)
  );

  assign mode_o = mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_o   <= 1'b0;
      count_o <= '0;
    end else begin
      out_o   <= lvl;
      count_o <= shown;
    end
  end

endmodule

// File: rtl/pit_channel_chk.sv
module pit_channel_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          tick,
  input logic          gate,
  input logic          wr_mode,
  input logic [2:0]    mode_i,
  input logic          wr_cnt,
  input logic          out_o,
  input logic [CW-1:0] count_o,
  input logic [2:0]    mode_o
);

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (!out_o && count_o == '0 && mode_o == 3'd0));

  p_flag_holds_r3: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 3'd0 && out_o && !wr_mode && !wr_cnt) |=> out_o);

  p_oneshot_idle_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_mode && mode_i == 3'd1) |=> out_o);

  p_strobe_single_r7: assert property (@(posedge clk) disable iff (rst)
    ((mode_o == 3'd4 || mode_o == 3'd5) && out_o && tick && gate
     && !wr_mode && !wr_cnt) |=> !out_o);

  p_mode_folded_r10: assert property (@(posedge clk) disable iff (rst)
    mode_o <= 3'd5);

  p_no_tick_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (!tick && !wr_mode && !wr_cnt && $stable(gate)) |=> $stable(count_o));

endmodule

bind pit_channel pit_channel_chk #(.CW(CW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .tick    (tick),
  .gate    (gate),
  .wr_mode (wr_mode),
  .mode_i  (mode_i),
  .wr_cnt  (wr_cnt),
  .out_o   (out_o),
  .count_o (count_o),
  .mode_o  (mode_o)
);

// File: tb/pit_channel_tb_top.sv
`timescale 1ns/1ps
module pit_channel_tb_top;

  localparam int CW = 16;
  localparam int NV = 33;

  typedef struct packed {
    logic        wm;
    logic [2:0]  md;
    logic        wc;
    logic [15:0] cv;
    logic        tk;
    logic        eo;
    logic [15:0] ec;
    logic [3:0]  rq;
  } vec_t;

  // Gate held high throughout the table.
  localparam vec_t VECS [NV] = '{
    '{1'b1, 3'd2, 1'b0, 16'd0, 1'b0, 1'b0, 16'h0000, 4'd13},
    '{1'b0, 3'd0, 1'b1, 16'd3, 1'b0, 1'b0, 16'h0003, 4'd11},
    '{1'b0, 3'd0, 1'b0, 16'd0, 1'b1, 1'b0, 16'h0002, 4'd5},
    '{1'b0, 3'd0, 1'b0, 16'd0, 1'b1, 1'b0, 16'h0001, 4'd5},
    '{1'b0, 3'd0, 1'b0, 16'd0, 1'b1, 1'b1, 16'h0003, 4'd5},
    '{1'b0, 3'd0, 1'b0, 16'd0, 1'b1, 1'b0, 16'h0002, 4'd5},
    '{1'b0, 3'd0, 1'b0, 16'd0, 1'b1, 1'b0, 16'h0001, 4'd5},
    '{1'b0, 3'd0, 1'b0, 16'd0, 1'b1, 1'b1, 16'h0003, 4'd5},
    '{1'b1, 3'd3, 1'b0, 16'd0, 1'b0, 1'b1, 16'h0000, 4'd13},
    '{1'b0, 3'd0, 1'b1, 16'd5, 1'b0, 1'b1, 16'h0005, 4'd6},
    '{1'b0, 3'd0, 1'b0, 16'd0, 1'b1, 1'b1, 16'h0003, 4'd6},
    '{1'b0, 3'd0, 1'b0, 16'd0, 1'b1, 1'b1, 16'h0001, 4'd6},
    '{1'b0, 3'd0, 1'b0, 16'd0, 1'b1, 1'b0, 16'h0004, 4'd6},
    '{1'b0, 3'd0, 1'b0, 16'd0, 1'b1, 1'b0, 16'h0002, 4'd6},
    '{1'b0, 3'd0, 1'b0, 16'd0, 1'b1, 1'b1, 16'h0005, 4'd6},
    '{1'b1, 3'd0, 1'b0, 16'd0, 1'b0, 1'b0, 16'h0000, 4'd13},
    '{1'b0, 3'd0, 1'b1, 16'd3, 1'b0, 1'b0, 16'h0003, 4'd3},
    '{1'b0, 3'd0, 1'b0, 16'd0, 1'b1, 1'b0, 16'h0002, 4'd3},
    '{1'b0, 3'd0, 1'b0, 16'd0, 1'b1, 1'b0, 16'h0001, 4'd3},
    '{1'b0, 3'd0, 1'b0, 16'd0, 1'b1, 1'b1, 16'h0000, 4'd3},
    '{1'b0, 3'd0, 1'b0, 16'd0, 1'b1, 1'b1, 16'hffff, 4'd3},
    '{1'b1, 3'd4, 1'b0, 16'd0, 1'b0, 1'b0, 16'h0000, 4'd13},
    '{1'b0, 3'd0, 1'b1, 16'd2, 1'b0, 1'b0, 16'h0002, 4'd7},
    '{1'b0, 3'd0, 1'b0, 16'd0, 1'b1, 1'b0, 16'h0001, 4'd7},
    '{1'b0, 3'd0, 1'b0, 16'd0, 1'b1, 1'b1, 16'h0000, 4'd7},
    '{1'b0, 3'd0, 1'b0, 16'd0, 1'b1, 1'b0, 16'hffff, 4'd7},
    '{1'b0, 3'd0, 1'b0, 16'd0, 1'b1, 1'b0, 16'hfffe, 4'd7},
    '{1'b1, 3'd6, 1'b0, 16'd0, 1'b0, 1'b0, 16'h0000, 4'd10},
    '{1'b0, 3'd0, 1'b1, 16'd2, 1'b0, 1'b0, 16'h0002, 4'd10},
    '{1'b0, 3'd0, 1'b0, 16'd0, 1'b1, 1'b0, 16'h0001, 4'd10},
    '{1'b0, 3'd0, 1'b0, 16'd0, 1'b1, 1'b1, 16'h0002, 4'd10},
    '{1'b0, 3'd0, 1'b0, 16'd0, 1'b0, 1'b1, 16'h0002, 4'd12},
    '{1'b0, 3'd0, 1'b0, 16'd0, 1'b1, 1'b0, 16'h0001, 4'd10}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tick = 1'b0;
  logic          gate = 1'b1;
  logic          wr_mode = 1'b0;
  logic [2:0]    mode_i = 3'd0;
  logic          bcd_i = 1'b0;
  logic          wr_cnt = 1'b0;
  logic [CW-1:0] count_i = '0;
  logic          out_o;
  logic [CW-1:0] count_o;
  logic [2:0]    mode_o;
  logic          bcd_o;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  pit_channel #(.CW(CW)) dut_i (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .gate    (gate),
    .wr_mode (wr_mode),
    .mode_i  (mode_i),
    .bcd_i   (bcd_i),
    .wr_cnt  (wr_cnt),
    .count_i (count_i),
    .out_o   (out_o),
    .count_o (count_o),
    .mode_o  (mode_o),
    .bcd_o   (bcd_o)
  );

  task automatic cyc(input logic wm, input logic [2:0] md, input logic wc,
                     input logic [15:0] cv, input logic tk, input logic gt);
    @(negedge clk);
    wr_mode = wm; mode_i = md; wr_cnt = wc; count_i = cv; tick = tk; gate = gt;
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input logic eo, input logic [15:0] ec, input string tag);
    checks++;
    if (out_o !== eo || count_o !== ec) begin
      fails++;
      $display("FAIL %s: out=%0b count=%h, expected out=%0b count=%h",
               tag, out_o, count_o, eo, ec);
    end
  endtask

  task automatic chk_cfg(input logic [2:0] em, input logic eb, input string tag);
    checks++;
    if (mode_o !== em || bcd_o !== eb) begin
      fails++;
      $display("FAIL %s: mode=%0d bcd=%0b, expected mode=%0d bcd=%0b",
               tag, mode_o, bcd_o, em, eb);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    cyc(0, 3'd0, 0, 16'd0, 0, 1);
    cyc(0, 3'd0, 0, 16'd0, 0, 1);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    // R1: reset state, and a count write before any mode write is ignored
    do_reset();
    #1;
    chk(1'b0, 16'h0000, "R1 reset outputs");
    chk_cfg(3'd0, 1'b0, "R1 reset mode/bcd");
    cyc(0, 3'd0, 1, 16'd5, 0, 1);
    chk(1'b0, 16'h0000, "R1 count write before mode");
    cyc(0, 3'd0, 0, 16'd0, 1, 1);
    chk(1'b0, 16'h0000, "R1 tick before mode");

    do_reset();
    for (int i = 0; i < NV; i++) begin
      cyc(VECS[i].wm, VECS[i].md, VECS[i].wc, VECS[i].cv, VECS[i].tk, 1'b1);
      chk(VECS[i].eo, VECS[i].ec, $sformatf("R%0d table row %0d", VECS[i].rq, i));
    end

    // R4 and R8: gate-triggered one-shot with a retrigger
    cyc(1, 3'd1, 0, 16'd0, 0, 0);  chk(1'b1, 16'h0000, "R4 idle after mode write");
    cyc(0, 3'd0, 1, 16'd3, 0, 0);  chk(1'b1, 16'h0003, "R4 high after count write");
    cyc(0, 3'd0, 0, 16'd0, 1, 0);
    cyc(0, 3'd0, 0, 16'd0, 1, 0);  chk(1'b1, 16'h0003, "R4 no count before trigger");
    cyc(0, 3'd0, 0, 16'd0, 0, 1);  chk(1'b0, 16'h0003, "R4 trigger drives low");
    cyc(0, 3'd0, 0, 16'd0, 1, 1);  chk(1'b0, 16'h0002, "R4 counting");
    cyc(0, 3'd0, 0, 16'd0, 1, 1);  chk(1'b0, 16'h0001, "R4 counting");
    cyc(0, 3'd0, 0, 16'd0, 0, 0);  chk(1'b0, 16'h0001, "R8 gate fall no effect");
    cyc(0, 3'd0, 0, 16'd0, 0, 1);  chk(1'b0, 16'h0003, "R8 one-shot retrigger");
    cyc(0, 3'd0, 0, 16'd0, 1, 1);
    cyc(0, 3'd0, 0, 16'd0, 1, 1);  chk(1'b0, 16'h0001, "R4 still low");
    cyc(0, 3'd0, 0, 16'd0, 1, 1);  chk(1'b1, 16'h0000, "R4 high at terminal");

    // R7: gate strobe
    cyc(1, 3'd5, 0, 16'd0, 0, 0);  chk(1'b0, 16'h0000, "R13 mode 5 idle low");
    cyc(0, 3'd0, 1, 16'd2, 0, 0);  chk(1'b0, 16'h0002, "R7 armed");
    cyc(0, 3'd0, 0, 16'd0, 0, 1);  chk(1'b0, 16'h0002, "R8 strobe trigger");
    cyc(0, 3'd0, 0, 16'd0, 1, 1);  chk(1'b0, 16'h0001, "R7 counting");
    cyc(0, 3'd0, 0, 16'd0, 1, 1);  chk(1'b1, 16'h0000, "R7 strobe high");
    cyc(0, 3'd0, 0, 16'd0, 1, 1);  chk(1'b0, 16'hffff, "R7 strobe single tick");

    // R9: gate level suspends mode 0
    cyc(1, 3'd0, 0, 16'd0, 0, 1);
    cyc(0, 3'd0, 1, 16'd4, 0, 1);  chk(1'b0, 16'h0004, "R11 load mode 0");
    cyc(0, 3'd0, 0, 16'd0, 1, 1);  chk(1'b0, 16'h0003, "R9 counts with gate high");
    cyc(0, 3'd0, 0, 16'd0, 1, 0);
    cyc(0, 3'd0, 0, 16'd0, 1, 0);
    cyc(0, 3'd0, 0, 16'd0, 1, 0);  chk(1'b0, 16'h0003, "R9 held with gate low");
    cyc(0, 3'd0, 0, 16'd0, 1, 1);  chk(1'b0, 16'h0002, "R9 no restart on edge");

    // R6: even square period
    cyc(1, 3'd3, 0, 16'd0, 0, 1);
    cyc(0, 3'd0, 1, 16'd4, 0, 1);  chk(1'b1, 16'h0004, "R6 even load");
    cyc(0, 3'd0, 0, 16'd0, 1, 1);  chk(1'b1, 16'h0002, "R6 even t1");
    cyc(0, 3'd0, 0, 16'd0, 1, 1);  chk(1'b0, 16'h0004, "R6 even t2");
    cyc(0, 3'd0, 0, 16'd0, 1, 1);  chk(1'b0, 16'h0002, "R6 even t3");
    cyc(0, 3'd0, 0, 16'd0, 1, 1);  chk(1'b1, 16'h0004, "R6 even wrap");

    // R8: rate mode gate retrigger
    cyc(1, 3'd2, 0, 16'd0, 0, 1);
    cyc(0, 3'd0, 1, 16'd4, 0, 1);
    cyc(0, 3'd0, 0, 16'd0, 1, 1);
    cyc(0, 3'd0, 0, 16'd0, 1, 1);  chk(1'b0, 16'h0002, "R5 rate counting");
    cyc(0, 3'd0, 0, 16'd0, 1, 0);  chk(1'b0, 16'h0002, "R9 rate held by gate");
    cyc(0, 3'd0, 0, 16'd0, 0, 1);  chk(1'b0, 16'h0004, "R8 rate retrigger");

    // R10 and R13: mode 7 folding, bcd stored
    bcd_i = 1'b1;
    cyc(1, 3'd7, 0, 16'd0, 0, 1);
    chk_cfg(3'd3, 1'b1, "R10 field 7 reads as 3, R13 bcd");
    chk(1'b1, 16'h0000, "R13 mode 3 idle high");
    bcd_i = 1'b0;

    // R11: new count mid-run restarts the period
    cyc(1, 3'd4, 0, 16'd0, 0, 1);
    cyc(0, 3'd0, 1, 16'd5, 0, 1);
    cyc(0, 3'd0, 0, 16'd0, 1, 1);
    cyc(0, 3'd0, 0, 16'd0, 1, 1);  chk(1'b0, 16'h0003, "R11 before rewrite");
    cyc(0, 3'd0, 1, 16'd2, 0, 1);  chk(1'b0, 16'h0002, "R11 rewrite");
    cyc(0, 3'd0, 0, 16'd0, 1, 1);
    cyc(0, 3'd0, 0, 16'd0, 1, 1);  chk(1'b1, 16'h0000, "R11 new period strobe");

    // R12: sparse ticks
    cyc(1, 3'd0, 0, 16'd0, 0, 1);
    cyc(0, 3'd0, 1, 16'd2, 0, 1);
    cyc(0, 3'd0, 0, 16'd0, 0, 1);
    cyc(0, 3'd0, 0, 16'd0, 0, 1);  chk(1'b0, 16'h0002, "R12 no tick");
    cyc(0, 3'd0, 0, 16'd0, 1, 1);  chk(1'b0, 16'h0001, "R12 one tick");
    cyc(0, 3'd0, 0, 16'd0, 0, 1);  chk(1'b0, 16'h0001, "R12 gap");
    cyc(0, 3'd0, 0, 16'd0, 1, 1);  chk(1'b1, 16'h0000, "R12 second tick");

    // R2: zero count is a full 65536 period
    cyc(1, 3'd0, 0, 16'd0, 0, 1);
    cyc(0, 3'd0, 1, 16'd0, 0, 1);  chk(1'b0, 16'h0000, "R2 zero load");
    cyc(0, 3'd0, 0, 16'd0, 1, 1);  chk(1'b0, 16'hffff, "R2 first tick");
    repeat (65534) cyc(0, 3'd0, 0, 16'd0, 1, 1);
    chk(1'b0, 16'h0001, "R2 one tick short");
    cyc(0, 3'd0, 0, 16'd0, 1, 1);  chk(1'b1, 16'h0000, "R2 terminal");

    finish_run();
  end

endmodule